// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns one road's full-resolution hit coordinates into track parameters and a fit-quality figure. It never evaluates the circle equation. Each road carries a sector number, and that number selects a stored set of coefficients. Each output parameter is a stored offset plus a weighted sum of the hit coordinates. The weights are computed offline and kept in a small coefficient memory.

The fit-quality figure comes from several constraint rows. Each row's weighted sum of the hits is squared, and the squares are added. An arithmetic right shift follows every accumulation, so all arithmetic stays in fixed point. A track is flagged as passing when its quality figure is below a limit supplied on an input.

The datapath is a three-stage pipeline. It accepts a new hit set on every clock and returns each result a fixed number of cycles later. A separate write port fills the coefficient memory one word at a time.

Top module: `lf_fit`

## Requirements
- R1: Impact parameter, azimuth and curvature come from coefficient rows 0, 1 and 2. Each equals (sum over layers i of coef[row][i] * hit[i]) arithmetically shifted right by 8 (rounding towards minus infinity), plus the row's constant stored in column 6. Hits are 12-bit signed, coefficients and constants 16-bit signed, results 32-bit signed.
- R2: The quality value uses the three constraint rows 3, 4 and 5. For each row k, t_k = (sum over i of coef[k][i] * hit[i]) >>> 6. The value is then (t_3^2 + t_4^2 + t_5^2) >> 4, as a 64-bit unsigned result.
- R3: A hit set presented with fit_valid_i high before clock edge n gives its result with trk_valid_o high after edge n+2. Inputs on consecutive clocks give results on consecutive clocks, in input order.
- R4: The coefficient set is chosen by the sector number, which is the top 3 bits of the 12-bit road identifier. The lower 9 bits do not affect the result.
- R5: A load write with ld_we_i high stores ld_data_i at ld_addr_i, laid out as {sector[8:6], row[5:3], column[2:0]}. Columns 0 to 5 hold the per-layer weights and column 6 the constant. The constants of rows 3 to 5 take no part in any result.
- R6: A load write and a fit to the same sector may arrive in the same cycle. The fit then uses the coefficients as they stood before the write, and a fit in the next cycle uses the written value.
- R7: trk_pass_o is high exactly when the quality value is strictly less than chi_max_i, with chi_max_i sampled on the edge that registers the result.
- R8: While rst_ni is low, trk_valid_o and trk_pass_o are low and every result output is zero.
- R9: A cycle with fit_valid_i low produces no result. trk_valid_o never rises except for an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fit_valid_i | input | 1 | Hit set and road are valid this cycle |
| fit_road_i | input | 12 | Road identifier; top 3 bits are the sector |
| fit_hits_i | input | 72 | Six 12-bit signed coordinates, layer i at bits [12i+11:12i] |
| ld_we_i | input | 1 | Coefficient write strobe |
| ld_addr_i | input | 9 | Coefficient address {sector, row, column} |
| ld_data_i | input | 16 | Coefficient or constant, signed |
| chi_max_i | input | 64 | Quality limit for the pass flag |
| trk_valid_o | output | 1 | Result valid |
| trk_ip_o | output | 32 | Impact parameter, signed |
| trk_phi_o | output | 32 | Azimuth, signed |
| trk_curv_o | output | 32 | Curvature, signed |
| trk_chi_o | output | 64 | Quality value |
| trk_pass_o | output | 1 | Quality value below limit |

## Verification
A coefficient write and a fit that reads the same sector can land in one clock. The bench forces this by driving a write to a weight of sector 2 in the very cycle that a sector 2 hit set enters. The same hits follow one cycle later. The scoreboard's shadow copy of the memory is updated only after the first fit's expected values are taken, so the first result must show the old weight and the second result the new one.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int N_LAYERS  = 6;
  localparam int HIT_W     = 12;
  localparam int COEF_W    = 16;
  localparam int N_PAR     = 3;
  localparam int N_CHI     = 3;
  localparam int N_ROWS    = N_PAR + N_CHI;
  localparam int N_COLS    = N_LAYERS + 1;
  localparam int ROAD_W    = 12;
  localparam int SECT_W    = 3;
  localparam int N_SECT    = 1 << SECT_W;
  localparam int ROW_AW    = $clog2(N_ROWS);
  localparam int COL_AW    = $clog2(N_COLS);
  localparam int ADDR_W    = SECT_W + ROW_AW + COL_AW;
  localparam int ACC_W     = HIT_W + COEF_W + $clog2(N_LAYERS);
  localparam int PAR_W     = ACC_W + 1;
  localparam int CHI_W     = 2 * PAR_W;
  localparam int PAR_SHIFT = 8;
  localparam int CHI_SHIFT = 6;
  localparam int SQ_SHIFT  = 4;
  localparam int SET_W     = N_ROWS * N_COLS * COEF_W;
  localparam int ROWV_W    = N_COLS * COEF_W;
endpackage

// File: rtl/lf_coef_store.sv
module lf_coef_store import lf_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COEF_W-1:0] data_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [SET_W-1:0]  set_o
);
  logic [COEF_W-1:0] mem [N_SECT][N_ROWS][N_COLS];

  logic [SECT_W-1:0] w_s;
  logic [ROW_AW-1:0] w_r;
  logic [COL_AW-1:0] w_c;
  logic              wr_hit;

  assign w_s    = addr_i[ADDR_W-1 -: SECT_W];
  assign w_r    = addr_i[COL_AW +: ROW_AW];
  assign w_c    = addr_i[COL_AW-1:0];
  assign wr_hit = we_i && (int'(w_r) < N_ROWS) && (int'(w_c) < N_COLS);

  always_ff @(posedge clk_i) begin
    if (wr_hit) mem[w_s][w_r][w_c] <= data_i;
  end

  // read-before-write: a same-edge write is seen by the next read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o <= '0;
    end else begin
      for (int r = 0; r < N_ROWS; r++)
        for (int c = 0; c < N_COLS; c++)
          set_o[(r*N_COLS+c)*COEF_W +: COEF_W] <= mem[sect_i][r][c];
    end
  end

  p_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> mem[$past(w_s)][$past(w_r)][$past(w_c)] == $past(data_i));
endmodule

// File: rtl/lf_dot.sv
module lf_dot import lf_pkg::*; #(
  parameter int SHIFT     = 8,
  parameter bit USE_CONST = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LAYERS*HIT_W-1:0] hits_i,
  input  logic [ROWV_W-1:0]       coef_i,
  output logic signed [PAR_W-1:0] dot_o
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_sh;
  logic signed [PAR_W-1:0] res;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_LAYERS; i++)
      acc = acc + ACC_W'($signed(hits_i[i*HIT_W +: HIT_W]))
                * ACC_W'($signed(coef_i[i*COEF_W +: COEF_W]));
    acc_sh = acc >>> SHIFT;
  end

  generate
    if (USE_CONST) begin : g_const
      assign res = PAR_W'(acc_sh) + PAR_W'($signed(coef_i[N_LAYERS*COEF_W +: COEF_W]));
    end else begin : g_noconst
      logic unused_const;
      assign unused_const = ^coef_i[N_LAYERS*COEF_W +: COEF_W];
      assign res = PAR_W'(acc_sh);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dot_o <= '0;
    else         dot_o <= res;
  end
endmodule

// File: rtl/lf_fit.sv
module lf_fit import lf_pkg::*; (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fit_valid_i,
  input  logic [ROAD_W-1:0]         fit_road_i,
  input  logic [N_LAYERS*HIT_W-1:0] fit_hits_i,
  input  logic                      ld_we_i,
  input  logic [ADDR_W-1:0]         ld_addr_i,
  input  logic [COEF_W-1:0]         ld_data_i,
  input  logic [CHI_W-1:0]          chi_max_i,
  output logic                      trk_valid_o,
  output logic signed [PAR_W-1:0]   trk_ip_o,
  output logic signed [PAR_W-1:0]   trk_phi_o,
  output logic signed [PAR_W-1:0]   trk_curv_o,
  output logic [CHI_W-1:0]          trk_chi_o,
  output logic                      trk_pass_o
);
  logic [SECT_W-1:0] sect;
  logic              unused_road;
  assign sect        = fit_road_i[ROAD_W-1 -: SECT_W];
  assign unused_road = ^fit_road_i[ROAD_W-SECT_W-1:0];

  // stage 1: hits and coefficient set
  logic [SET_W-1:0]          set1;
  logic                      v1_q;
  logic [N_LAYERS*HIT_W-1:0] hits1_q;

  lf_coef_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ld_we_i),
    .addr_i (ld_addr_i),
    .data_i (ld_data_i),
    .sect_i (sect),
    .set_o  (set1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      hits1_q <= '0;
    end else begin
      v1_q    <= fit_valid_i;
      hits1_q <= fit_hits_i;
    end
  end

  // stage 2: one dot product per coefficient row
  logic signed [PAR_W-1:0] dot2 [N_ROWS];
  logic                    v2_q;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    lf_dot #(
      .SHIFT     ((r < N_PAR) ? PAR_SHIFT : CHI_SHIFT),
      .USE_CONST (r < N_PAR)
    ) u_dot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hits_i (hits1_q),
      .coef_i (set1[r*ROWV_W +: ROWV_W]),
      .dot_o  (dot2[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v2_q <= 1'b0;
    else         v2_q <= v1_q;
  end

  // stage 3: sum of squares, limit compare, output registers
  logic [CHI_W-1:0] sq_sum;
  logic [CHI_W-1:0] chi_n;

  always_comb begin
    sq_sum = '0;
    for (int k = 0; k < N_CHI; k++) begin
      logic signed [CHI_W-1:0] dk;
      dk     = CHI_W'(dot2[N_PAR+k]);
      sq_sum = sq_sum + CHI_W'(dk * dk);
    end
    chi_n = sq_sum >> SQ_SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_valid_o <= 1'b0;
      trk_ip_o    <= '0;
      trk_phi_o   <= '0;
      trk_curv_o  <= '0;
      trk_chi_o   <= '0;
      trk_pass_o  <= 1'b0;
    end else begin
      trk_valid_o <= v2_q;
      trk_ip_o    <= dot2[0];
      trk_phi_o   <= dot2[1];
      trk_curv_o  <= dot2[2];
      trk_chi_o   <= chi_n;
      trk_pass_o  <= v2_q && (chi_n < chi_max_i);
    end
  end

  // cycles since reset, for history-based checks only
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (trk_valid_o == $past(fit_valid_i, 3)));

  p_pass_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && trk_valid_o) |-> (trk_pass_o == (trk_chi_o < $past(chi_max_i))));

  p_chi_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v2_q && (dot2[3] == '0) && (dot2[4] == '0) && (dot2[5] == '0)) |=> (trk_chi_o == '0));

  p_no_pass_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trk_valid_o |-> !trk_pass_o);
endmodule

// File: tb/lf_fit_tb.sv
module lf_fit_tb;
  import lf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fit_valid_i = 1'b0;
  logic [ROAD_W-1:0] fit_road_i = '0;
  logic [N_LAYERS*HIT_W-1:0] fit_hits_i = '0;
  logic ld_we_i = 1'b0;
  logic [ADDR_W-1:0] ld_addr_i = '0;
  logic [COEF_W-1:0] ld_data_i = '0;
  logic [CHI_W-1:0] chi_max_i = '0;
  logic trk_valid_o, trk_pass_o;
  logic signed [PAR_W-1:0] trk_ip_o, trk_phi_o, trk_curv_o;
  logic [CHI_W-1:0] trk_chi_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lf_fit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fit_valid_i(fit_valid_i), .fit_road_i(fit_road_i),
    .fit_hits_i(fit_hits_i), .ld_we_i(ld_we_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .chi_max_i(chi_max_i), .trk_valid_o(trk_valid_o), .trk_ip_o(trk_ip_o),
    .trk_phi_o(trk_phi_o), .trk_curv_o(trk_curv_o), .trk_chi_o(trk_chi_o), .trk_pass_o(trk_pass_o)
  );

  typedef struct {
    longint ip, phi, curv, chi;
    bit     pass;
    int     cyc;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     total = 0, bad = 0, cyc = 0;
  longint shadow [N_SECT][N_ROWS][N_COLS];
  longint thr = 64'sh7fff_ffff_ffff_ffff;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int sec, input int h[N_LAYERS],
                                output longint p[N_PAR], output longint chi);
    longint s, acc;
    s = 0;
    for (int r = 0; r < N_ROWS; r++) begin
      acc = 0;
      for (int i = 0; i < N_LAYERS; i++) acc += shadow[sec][r][i] * h[i];
      if (r < N_PAR) p[r] = (acc >>> PAR_SHIFT) + shadow[sec][r][N_LAYERS];
      else begin
        acc = acc >>> CHI_SHIFT;
        s += acc * acc;
      end
    end
    chi = s >>> SQ_SHIFT;
  endfunction

  function automatic longint coef_val(input int s, input int r, input int c);
    return longint'((((s*37 + r*11 + c*5 + 3) % 61) - 30) * 97);
  endfunction

  // one clock of stimulus; expected values use coefficients before this cycle's write
  task automatic step(input bit fv, input int sec, input int low, input int h[N_LAYERS],
                      input bit we, input int wa, input longint wd, input string tag);
    exp_t e;
    longint p[N_PAR];
    fit_valid_i = fv;
    fit_road_i  = ROAD_W'((sec << (ROAD_W-SECT_W)) | low);
    for (int i = 0; i < N_LAYERS; i++) fit_hits_i[i*HIT_W +: HIT_W] = HIT_W'(h[i]);
    ld_we_i   = we;
    ld_addr_i = ADDR_W'(wa);
    ld_data_i = COEF_W'(wd);
    chi_max_i = CHI_W'(thr);
    if (fv) begin
      model(sec, h, p, e.chi);
      e.ip = p[0]; e.phi = p[1]; e.curv = p[2];
      e.pass = (e.chi < thr);
      e.cyc = cyc + 3;
      e.tag = tag;
      sb.push_back(e);
    end
    if (we) begin
      int ws, wr, wc;
      ws = (wa >> (ROW_AW+COL_AW)) & (N_SECT-1);
      wr = (wa >> COL_AW) & ((1<<ROW_AW)-1);
      wc = wa & ((1<<COL_AW)-1);
      if (wr < N_ROWS && wc < N_COLS) shadow[ws][wr][wc] = longint'($signed(COEF_W'(wd)));
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    int z[N_LAYERS];
    for (int i = 0; i < N_LAYERS; i++) z[i] = 0;
    for (int k = 0; k < n; k++) step(0, 0, 0, z, 0, 0, 0, "");
  endtask

  function automatic int addr_of(input int s, input int r, input int c);
    return (s << (ROW_AW+COL_AW)) | (r << COL_AW) | c;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && trk_valid_o) begin
      if (sb.size() == 0) begin
        chk(0, "R9 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(longint'(trk_ip_o) == e.ip, {"R1 ip ", e.tag}, longint'(trk_ip_o), e.ip);
        chk(longint'(trk_phi_o) == e.phi, {"R1 phi ", e.tag}, longint'(trk_phi_o), e.phi);
        chk(longint'(trk_curv_o) == e.curv, {"R1 curv ", e.tag}, longint'(trk_curv_o), e.curv);
        chk(longint'(trk_chi_o) == e.chi, {"R2 chi ", e.tag}, longint'(trk_chi_o), e.chi);
        chk(cyc == e.cyc, {"R3 latency ", e.tag}, cyc, e.cyc);
        chk(trk_pass_o == e.pass, {"R7 pass ", e.tag}, trk_pass_o, e.pass);
      end
    end
  end

  initial begin
    int h[N_LAYERS];
    longint p[N_PAR];
    longint c0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!trk_valid_o && !trk_pass_o, "R8 flags in reset", trk_valid_o, 0);
    chk(trk_ip_o == 0 && trk_phi_o == 0 && trk_curv_o == 0 && trk_chi_o == 0,
        "R8 data in reset", longint'(trk_ip_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 load all sectors, chi-row constants nonzero but unused
    for (int s = 0; s < N_SECT; s++)
      for (int r = 0; r < N_ROWS; r++)
        for (int c = 0; c < N_COLS; c++) begin
          for (int i = 0; i < N_LAYERS; i++) h[i] = 0;
          step(0, 0, 0, h, 1, addr_of(s, r, c), coef_val(s, r, c), "");
        end
    idle(2);
    chk(sb.size() == 0 && !trk_valid_o, "R9 idle during load", trk_valid_o, 0);

    // R1 zero hits give constants
    for (int i = 0; i < N_LAYERS; i++) h[i] = 0;
    step(1, 0, 5, h, 0, 0, 0, "zero-hits R5");
    // extremes
    for (int i = 0; i < N_LAYERS; i++) h[i] = 2047;
    step(1, 7, 0, h, 0, 0, 0, "max-hits");
    for (int i = 0; i < N_LAYERS; i++) h[i] = -2048;
    step(1, 3, 511, h, 0, 0, 0, "min-hits");
    for (int i = 0; i < N_LAYERS; i++) h[i] = (i % 2) ? -1 : 1;
    step(1, 4, 0, h, 0, 0, 0, "alt-hits floor");
    idle(5);

    // R4 same hits, different sectors, low road bits vary
    for (int i = 0; i < N_LAYERS; i++) h[i] = 300 - 170*i;
    step(1, 1, 0, h, 0, 0, 0, "R4 sector1");
    step(1, 5, 0, h, 0, 0, 0, "R4 sector5");
    step(1, 5, 377, h, 0, 0, 0, "R4 low-bits");
    idle(5);

    // R3 back-to-back stream
    for (int n = 0; n < 48; n++) begin
      for (int i = 0; i < N_LAYERS; i++) h[i] = int'($urandom_range(4095)) - 2048;
      step(1, n % N_SECT, int'($urandom_range(511)), h, 0, 0, 0, "R3 stream");
    end
    // R9 bubbles
    for (int i = 0; i < N_LAYERS; i++) h[i] = 17*i - 40;
    step(1, 6, 0, h, 0, 0, 0, "R9 bubble");
    idle(1);
    step(1, 2, 0, h, 0, 0, 0, "R9 bubble");
    idle(2);
    step(1, 0, 0, h, 0, 0, 0, "R9 bubble");
    idle(6);

    // R6 write and fit to the same sector in one cycle
    for (int i = 0; i < N_LAYERS; i++) h[i] = 1000;
    c0 = shadow[2][0][0];
    step(1, 2, 0, h, 1, addr_of(2, 0, 0), 16'sd12345, "R6 old coef");
    step(1, 2, 0, h, 0, 0, 0, "R6 new coef");
    chk(shadow[2][0][0] != c0, "R6 write differs", shadow[2][0][0], c0);
    idle(6);

    // R7 limit boundary
    for (int i = 0; i < N_LAYERS; i++) h[i] = 900 - 311*i;
    model(3, h, p, c0);
    thr = c0;
    step(1, 3, 0, h, 0, 0, 0, "R7 equal");
    idle(4);
    thr = c0 + 1;
    step(1, 3, 0, h, 0, 0, 0, "R7 above");
    idle(4);
    thr = 0;
    step(1, 3, 0, h, 0, 0, 0, "R7 zero");
    idle(4);
    thr = 64'sh7fff_ffff_ffff_ffff;

    idle(4);
    chk(sb.size() == 0, "R9 all results returned", sb.size(), 0);
    chk(!trk_valid_o, "R9 quiet at end", trk_valid_o, 0);
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
    if (!done) chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule